// File: doc/BRIEF.md
# Scalar Register Busy Scoreboard

This block tracks, for every physical register of a scalar register file shared by one compute unit, whether a result is still pending. The issue logic presents a candidate instruction as short lists of physical source and destination indices, each slot with its own valid bit. The block answers in the same cycle whether the instruction may go. When it may not, the block names the cause: a source still waiting for its producer (read-after-write), or a destination still owned by an earlier writer (write-after-any).

Issuing an instruction marks its destinations busy. Two paths make them free again. An arithmetic-class instruction arms a per-register countdown at execute, and the busy bit drops a fixed scalar-pipe latency later. A memory-class instruction (load, returning atomic, memory sync) arms nothing: its destinations stay busy until a writeback port names them. Four counters record blocked queries by cause, source dwords read and destination dwords written.

An operand that spans several consecutive registers is presented as several index slots, so each register is checked, marked and freed on its own.

Top module: `scalar_busy_scoreboard`

## Requirements
- R1: If any valid source slot names a busy register, `q_ready` is 0 and `q_raw_stall` is 1, in the same cycle as the query.
- R2: If no valid source slot names a busy register but a valid destination slot does, `q_ready` is 0, `q_wax_stall` is 1 and `q_raw_stall` is 0. With no such hit, `q_ready` is 1.
- R3: On a clock edge with `q_check` high, `raw_cnt` increments by one if the query shows a source hit. Otherwise `wax_cnt` increments by one if it shows a destination hit. The two never increment on the same edge.
- R4: On an edge with `iss_en` high, every register named by a valid `iss_dst_idx` slot becomes busy, and this is visible from the following cycle.
- R5: On an edge with `ex_en` high and `ex_mem` 0, every register named by a valid `ex_dst_idx` slot becomes free exactly `PIPE_LAT` edges later. It stays busy after `PIPE_LAT`-1 edges.
- R6: An execute with `ex_mem` 1 does not free its destinations. They stay busy for any number of cycles until a writeback names them.
- R7: On an edge with `wb_en` high, every register named by a valid `wb_dst_idx` slot becomes free, visible from the following cycle.
- R8: If an issue marks a register on the same edge that a countdown expiry or a writeback frees it, the register ends busy.
- R9: On each edge with `ex_en` high, `rd_cnt` increases by the number of valid `ex_src_vld` bits.
- R10: `wr_cnt` increases by the number of valid `ex_dst_vld` bits on an execute with `ex_mem` 0, and by the number of valid `wb_dst_vld` bits on a writeback. An execute with `ex_mem` 1 adds nothing.
- R11: A slot whose valid bit is 0 has no effect on readiness, marking, freeing or counting, whatever index it holds.
- R12: After reset every register is free and all four counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_src_idx | input | NUM_SRC x IDX_W | Candidate source register indices |
| q_src_vld | input | NUM_SRC | Valid bit per source slot |
| q_dst_idx | input | NUM_DST x IDX_W | Candidate destination register indices |
| q_dst_vld | input | NUM_DST | Valid bit per destination slot |
| q_check | input | 1 | Count the current query's stall cause at this edge |
| q_ready | output | 1 | Candidate may issue |
| q_raw_stall | output | 1 | Blocked by a busy source |
| q_wax_stall | output | 1 | Blocked by a busy destination, sources free |
| iss_en | input | 1 | Issue: mark destinations busy |
| iss_dst_idx | input | NUM_DST x IDX_W | Destinations of the issued instruction |
| iss_dst_vld | input | NUM_DST | Valid bit per issued destination slot |
| ex_en | input | 1 | Execute event |
| ex_mem | input | 1 | 1 for load, returning atomic or memory sync |
| ex_src_vld | input | NUM_SRC | Valid source slots of the executing instruction |
| ex_dst_idx | input | NUM_DST x IDX_W | Destinations of the executing instruction |
| ex_dst_vld | input | NUM_DST | Valid bit per executing destination slot |
| wb_en | input | 1 | Memory writeback event |
| wb_dst_idx | input | NUM_DST x IDX_W | Registers written back |
| wb_dst_vld | input | NUM_DST | Valid bit per writeback slot |
| raw_cnt | output | CNT_W | Queries blocked by a source |
| wax_cnt | output | CNT_W | Queries blocked by a destination only |
| rd_cnt | output | CNT_W | Source dwords read |
| wr_cnt | output | CNT_W | Destination dwords written |

## Verification
The assertions assume the issue side respects the scoreboard. It issues only after a ready answer, so no register is marked again while its countdown is still running. It never arms a countdown on a register that is not busy. The bench keeps to this: it frees every register before reusing it, except in the deliberate same-edge set-and-clear cases, which rely only on set-wins. It also keeps all indices inside the register range, so no decode falls outside the busy array.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Number of set bits in a slot-valid vector (zero-extended by the caller).
  function automatic int unsigned sb_popcount(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      n += {31'd0, v[i]};
    end
    return n;
  endfunction

  // Bits needed to hold a countdown starting at lat.
  function automatic int sb_timer_width(input int lat);
    return (lat < 2) ? 1 : $clog2(lat + 1);
  endfunction

endpackage

// File: rtl/sb_index_decode.sv
module sb_index_decode #(
  parameter int NUM_REGS = 128,
  parameter int NUM_IDX  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                            en,
  input  logic [NUM_IDX-1:0][IDX_W-1:0]   idx,
  input  logic [NUM_IDX-1:0]              vld,
  output logic [NUM_REGS-1:0]             mask
);

  always_comb begin
    mask = '0;
    for (int i = 0; i < NUM_IDX; i++) begin
      if (en && vld[i] && (int'(idx[i]) < NUM_REGS)) begin
        mask[idx[i]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_busy_array.sv
module sb_busy_array
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int PIPE_LAT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_mask,
  input  logic [NUM_REGS-1:0] arm_mask,
  input  logic [NUM_REGS-1:0] wb_mask,
  output logic [NUM_REGS-1:0] busy,
  output logic [NUM_REGS-1:0] expire
);

  localparam int TW = sb_timer_width(PIPE_LAT);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [TW-1:0] tmr_q;
    logic          busy_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_q <= '0;
      end else if (arm_mask[r]) begin
        tmr_q <= TW'(PIPE_LAT);
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - TW'(1);
      end
    end

    assign expire[r] = (tmr_q == TW'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
      end else if (set_mask[r]) begin
        busy_r <= 1'b1;
      end else if (expire[r] || wb_mask[r]) begin
        busy_r <= 1'b0;
      end
    end

    assign busy[r] = busy_r;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[r] |=> busy_r);

    // R7
    wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_mask[r] && !set_mask[r]) |=> !busy_r);

    // R5
    expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[r] && !set_mask[r]) |=> !busy_r);
  end

endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
  parameter int NUM_REGS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] busy,
  input  logic [NUM_REGS-1:0] src_mask,
  input  logic [NUM_REGS-1:0] dst_mask,
  output logic                raw,
  output logic                wax,
  output logic                ready
);

  logic src_hit;
  logic dst_hit;

  assign src_hit = |(src_mask & busy);
  assign dst_hit = |(dst_mask & busy);
  assign raw     = src_hit;
  assign wax     = !src_hit && dst_hit;
  assign ready   = !(src_hit || dst_hit);

  // R1
  raw_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw |-> !ready);

endmodule

// File: rtl/sb_counters.sv
module sb_counters
  import sb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 2,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q_check,
  input  logic               raw,
  input  logic               wax,
  input  logic               ex_en,
  input  logic               ex_mem,
  input  logic [NUM_SRC-1:0] ex_src_vld,
  input  logic [NUM_DST-1:0] ex_dst_vld,
  input  logic               wb_en,
  input  logic [NUM_DST-1:0] wb_dst_vld,
  output logic [CNT_W-1:0]   raw_cnt,
  output logic [CNT_W-1:0]   wax_cnt,
  output logic [CNT_W-1:0]   rd_cnt,
  output logic [CNT_W-1:0]   wr_cnt
);

  logic             alu_ex;
  logic [CNT_W-1:0] rd_add;
  logic [CNT_W-1:0] wr_add_ex;
  logic [CNT_W-1:0] wr_add_wb;

  assign alu_ex    = ex_en && !ex_mem;
  assign rd_add    = ex_en  ? CNT_W'(sb_popcount(32'(ex_src_vld))) : '0;
  assign wr_add_ex = alu_ex ? CNT_W'(sb_popcount(32'(ex_dst_vld))) : '0;
  assign wr_add_wb = wb_en  ? CNT_W'(sb_popcount(32'(wb_dst_vld))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_cnt <= '0;
      wax_cnt <= '0;
      rd_cnt  <= '0;
      wr_cnt  <= '0;
    end else begin
      if (q_check && raw) begin
        raw_cnt <= raw_cnt + CNT_W'(1);
      end else if (q_check && wax) begin
        wax_cnt <= wax_cnt + CNT_W'(1);
      end
      rd_cnt <= rd_cnt + rd_add;
      wr_cnt <= wr_cnt + wr_add_ex + wr_add_wb;
    end
  end

  // R3
  one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_check && raw) |=> $stable(wax_cnt));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_en |=> $stable(rd_cnt));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_ex && !wb_en) |=> $stable(wr_cnt));

endmodule

// File: rtl/scalar_busy_scoreboard.sv
module scalar_busy_scoreboard #(
  parameter int NUM_REGS = 128,
  parameter int NUM_SRC  = 4,
  parameter int NUM_DST  = 2,
  parameter int PIPE_LAT = 4,
  parameter int CNT_W    = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] q_src_idx,
  input  logic [NUM_SRC-1:0]            q_src_vld,
  input  logic [NUM_DST-1:0][IDX_W-1:0] q_dst_idx,
  input  logic [NUM_DST-1:0]            q_dst_vld,
  input  logic                          q_check,
  output logic                          q_ready,
  output logic                          q_raw_stall,
  output logic                          q_wax_stall,
  input  logic                          iss_en,
  input  logic [NUM_DST-1:0][IDX_W-1:0] iss_dst_idx,
  input  logic [NUM_DST-1:0]            iss_dst_vld,
  input  logic                          ex_en,
  input  logic                          ex_mem,
  input  logic [NUM_SRC-1:0]            ex_src_vld,
  input  logic [NUM_DST-1:0][IDX_W-1:0] ex_dst_idx,
  input  logic [NUM_DST-1:0]            ex_dst_vld,
  input  logic                          wb_en,
  input  logic [NUM_DST-1:0][IDX_W-1:0] wb_dst_idx,
  input  logic [NUM_DST-1:0]            wb_dst_vld,
  output logic [CNT_W-1:0]              raw_cnt,
  output logic [CNT_W-1:0]              wax_cnt,
  output logic [CNT_W-1:0]              rd_cnt,
  output logic [CNT_W-1:0]              wr_cnt
);

  // Named internal events, visible to the assertions.
  logic [NUM_REGS-1:0] src_mask;
  logic [NUM_REGS-1:0] dst_mask;
  logic [NUM_REGS-1:0] set_mask;
  logic [NUM_REGS-1:0] arm_mask;
  logic [NUM_REGS-1:0] wb_mask;
  logic [NUM_REGS-1:0] busy;
  logic [NUM_REGS-1:0] expire;
  logic                alu_ex;

  assign alu_ex = ex_en && !ex_mem;

  sb_index_decode #(.NUM_REGS(NUM_REGS), .NUM_IDX(NUM_SRC)) u_dec_qsrc (
    .en(1'b1), .idx(q_src_idx), .vld(q_src_vld), .mask(src_mask));

  sb_index_decode #(.NUM_REGS(NUM_REGS), .NUM_IDX(NUM_DST)) u_dec_qdst (
    .en(1'b1), .idx(q_dst_idx), .vld(q_dst_vld), .mask(dst_mask));

  sb_index_decode #(.NUM_REGS(NUM_REGS), .NUM_IDX(NUM_DST)) u_dec_iss (
    .en(iss_en), .idx(iss_dst_idx), .vld(iss_dst_vld), .mask(set_mask));

  sb_index_decode #(.NUM_REGS(NUM_REGS), .NUM_IDX(NUM_DST)) u_dec_arm (
    .en(alu_ex), .idx(ex_dst_idx), .vld(ex_dst_vld), .mask(arm_mask));

  sb_index_decode #(.NUM_REGS(NUM_REGS), .NUM_IDX(NUM_DST)) u_dec_wb (
    .en(wb_en), .idx(wb_dst_idx), .vld(wb_dst_vld), .mask(wb_mask));

  sb_busy_array #(.NUM_REGS(NUM_REGS), .PIPE_LAT(PIPE_LAT)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .arm_mask(arm_mask), .wb_mask(wb_mask),
    .busy(busy), .expire(expire));

  sb_hazard_check #(.NUM_REGS(NUM_REGS)) u_hazard (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .src_mask(src_mask), .dst_mask(dst_mask),
    .raw(q_raw_stall), .wax(q_wax_stall), .ready(q_ready));

  sb_counters #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .q_check(q_check), .raw(q_raw_stall), .wax(q_wax_stall),
    .ex_en(ex_en), .ex_mem(ex_mem),
    .ex_src_vld(ex_src_vld), .ex_dst_vld(ex_dst_vld),
    .wb_en(wb_en), .wb_dst_vld(wb_dst_vld),
    .raw_cnt(raw_cnt), .wax_cnt(wax_cnt), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt));

  for (genvar g = 0; g < NUM_DST; g++) begin : g_iss_chk
    // R4
    issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_en && iss_dst_vld[g]) |=> busy[$past(iss_dst_idx[g])]);
  end

  // R2
  wax_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_wax_stall |-> (!q_raw_stall && !q_ready));

endmodule

// File: tb/sim_scalar_busy_scoreboard.sv
module sim_scalar_busy_scoreboard;

  localparam int NR = 128;
  localparam int NS = 4;
  localparam int ND = 2;
  localparam int LAT = 4;
  localparam int IW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0][IW-1:0] q_src_idx = '0;
  logic [NS-1:0]         q_src_vld = '0;
  logic [ND-1:0][IW-1:0] q_dst_idx = '0;
  logic [ND-1:0]         q_dst_vld = '0;
  logic q_check = 1'b0;
  logic q_ready, q_raw_stall, q_wax_stall;
  logic iss_en = 1'b0;
  logic [ND-1:0][IW-1:0] iss_dst_idx = '0;
  logic [ND-1:0]         iss_dst_vld = '0;
  logic ex_en = 1'b0, ex_mem = 1'b0;
  logic [NS-1:0]         ex_src_vld = '0;
  logic [ND-1:0][IW-1:0] ex_dst_idx = '0;
  logic [ND-1:0]         ex_dst_vld = '0;
  logic wb_en = 1'b0;
  logic [ND-1:0][IW-1:0] wb_dst_idx = '0;
  logic [ND-1:0]         wb_dst_vld = '0;
  logic [31:0] raw_cnt, wax_cnt, rd_cnt, wr_cnt;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_raw = 0, exp_wax = 0, exp_rd = 0, exp_wr = 0;

  always #10 clk = ~clk;

  scalar_busy_scoreboard #(.NUM_REGS(NR), .NUM_SRC(NS), .NUM_DST(ND),
                           .PIPE_LAT(LAT), .CNT_W(32)) u0 (
    .clk(clk), .rst_n(rst_n),
    .q_src_idx(q_src_idx), .q_src_vld(q_src_vld),
    .q_dst_idx(q_dst_idx), .q_dst_vld(q_dst_vld), .q_check(q_check),
    .q_ready(q_ready), .q_raw_stall(q_raw_stall), .q_wax_stall(q_wax_stall),
    .iss_en(iss_en), .iss_dst_idx(iss_dst_idx), .iss_dst_vld(iss_dst_vld),
    .ex_en(ex_en), .ex_mem(ex_mem), .ex_src_vld(ex_src_vld),
    .ex_dst_idx(ex_dst_idx), .ex_dst_vld(ex_dst_vld),
    .wb_en(wb_en), .wb_dst_idx(wb_dst_idx), .wb_dst_vld(wb_dst_vld),
    .raw_cnt(raw_cnt), .wax_cnt(wax_cnt), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt));

  function automatic int ones(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    iss_en = 0; iss_dst_vld = '0;
    ex_en = 0; ex_mem = 0; ex_src_vld = '0; ex_dst_vld = '0;
    wb_en = 0; wb_dst_vld = '0;
    q_check = 0; q_src_vld = '0; q_dst_vld = '0;
  endtask

  // Busy state of one register, seen as a single-source query.
  task automatic probe(input int r, output logic b);
    q_src_idx = '0; q_src_idx[0] = IW'(r); q_src_vld = 4'b0001;
    q_dst_vld = '0; q_check = 0;
    #1;
    b = q_raw_stall;
    q_src_vld = '0;
    #1;
  endtask

  task automatic issue(input int a, input int b, input logic [1:0] v);
    iss_en = 1; iss_dst_idx[0] = IW'(a); iss_dst_idx[1] = IW'(b); iss_dst_vld = v;
    step();
    idle();
  endtask

  task automatic wback(input int a, input int b, input logic [1:0] v);
    wb_en = 1; wb_dst_idx[0] = IW'(a); wb_dst_idx[1] = IW'(b); wb_dst_vld = v;
    exp_wr += ones({2'b00, v});
    step();
    idle();
  endtask

  task automatic check_counters(input string req);
    check({req, " raw_cnt"}, raw_cnt, exp_raw);
    check({req, " wax_cnt"}, wax_cnt, exp_wax);
    check({req, " rd_cnt"},  rd_cnt,  exp_rd);
    check({req, " wr_cnt"},  wr_cnt,  exp_wr);
  endtask

  task automatic t_reset();
    logic b;
    probe(0, b);   check("R12 reg0 free", b, 0);
    probe(127, b); check("R12 reg127 free", b, 0);
    check_counters("R12");
  endtask

  task automatic t_issue();
    logic b;
    iss_en = 1; iss_dst_idx[0] = 7'd5; iss_dst_idx[1] = 7'd6; iss_dst_vld = 2'b11;
    probe(5, b); check("R4 not busy before edge", b, 0);
    step(); idle();
    probe(5, b); check("R4 slot0 busy", b, 1);
    probe(6, b); check("R4 slot1 busy", b, 1);
    issue(9, 11, 2'b00);
    probe(9, b);  check("R11 invalid issue slot0", b, 0);
    probe(11, b); check("R11 invalid issue slot1", b, 0);
    wback(5, 6, 2'b11);
    probe(5, b); check("R7 wb frees slot0", b, 0);
    probe(6, b); check("R7 wb frees slot1", b, 0);
    issue(12, 0, 2'b01);
    wback(12, 13, 2'b10);
    probe(12, b); check("R11 invalid wb slot leaves busy", b, 1);
    wback(12, 0, 2'b01);
    probe(12, b); check("R7 wb frees 12", b, 0);
    check_counters("R10 wb");
  endtask

  task automatic t_raw_wax();
    issue(10, 20, 2'b11);
    q_src_idx[0] = 7'd3; q_src_idx[1] = 7'd10; q_src_vld = 4'b0011;
    q_dst_idx[0] = 7'd20; q_dst_vld = 2'b01; q_check = 1;
    #1;
    check("R1 raw ready", q_ready, 0);
    check("R1 raw stall", q_raw_stall, 1);
    check("R3 raw priority no wax", q_wax_stall, 0);
    exp_raw++;
    step();
    q_src_idx[0] = 7'd1; q_src_idx[1] = 7'd2; q_src_idx[2] = 7'd10; q_src_vld = 4'b0011;
    q_dst_idx[0] = 7'd20; q_dst_vld = 2'b01; q_check = 1;
    #1;
    check("R2 wax ready", q_ready, 0);
    check("R2 wax stall", q_wax_stall, 1);
    check("R11 invalid busy source ignored", q_raw_stall, 0);
    exp_wax++;
    step();
    q_dst_idx[0] = 7'd21; q_dst_idx[1] = 7'd20; q_dst_vld = 2'b01; q_check = 1;
    #1;
    check("R2 free ready", q_ready, 1);
    check("R2 free no wax", q_wax_stall, 0);
    step(); idle();
    check_counters("R3");
    wback(10, 20, 2'b11);
  endtask

  task automatic t_alu();
    logic b;
    issue(30, 31, 2'b11);
    ex_en = 1; ex_mem = 0; ex_src_vld = 4'b0111;
    ex_dst_idx[0] = 7'd30; ex_dst_idx[1] = 7'd31; ex_dst_vld = 2'b11;
    exp_rd += 3; exp_wr += 2;
    step(); idle();
    for (int i = 0; i < LAT - 1; i++) step();
    probe(30, b); check("R5 busy at LAT-1", b, 1);
    probe(31, b); check("R5 slot1 busy at LAT-1", b, 1);
    step();
    probe(30, b); check("R5 free at LAT", b, 0);
    probe(31, b); check("R5 slot1 free at LAT", b, 0);
    check_counters("R9 R10 alu");
  endtask

  task automatic t_mem();
    logic b;
    issue(40, 0, 2'b01);
    ex_en = 1; ex_mem = 1; ex_src_vld = 4'b1000;
    ex_dst_idx[0] = 7'd40; ex_dst_vld = 2'b01;
    exp_rd += 1;
    step(); idle();
    for (int i = 0; i < 2 * LAT; i++) step();
    probe(40, b); check("R6 mem dst still busy", b, 1);
    check("R10 mem ex adds no write", wr_cnt, exp_wr);
    wback(40, 0, 2'b01);
    probe(40, b); check("R6 freed by wb", b, 0);
    check_counters("R9 R10 mem");
  endtask

  task automatic t_set_wins();
    logic b;
    issue(50, 0, 2'b01);
    ex_en = 1; ex_mem = 0; ex_dst_idx[0] = 7'd50; ex_dst_vld = 2'b01;
    exp_wr += 1;
    step(); idle();
    for (int i = 0; i < LAT - 1; i++) step();
    issue(50, 0, 2'b01);
    probe(50, b); check("R8 set beats expiry", b, 1);
    for (int i = 0; i < LAT + 2; i++) step();
    probe(50, b); check("R8 stays busy after expiry", b, 1);
    iss_en = 1; iss_dst_idx[0] = 7'd50; iss_dst_vld = 2'b01;
    wb_en = 1; wb_dst_idx[0] = 7'd50; wb_dst_vld = 2'b01;
    exp_wr += 1;
    step(); idle();
    probe(50, b); check("R8 set beats wb", b, 1);
    wback(50, 0, 2'b01);
    probe(50, b); check("R7 final free", b, 0);
    check_counters("R8 R10");
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_issue();
    t_raw_wax();
    t_alu();
    t_mem();
    t_set_wins();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule